// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller with Port Sizing

This block sits between a processor's local request port and an external multiplexed address/data bus. It takes one read or write request at a time. Each request carries a word address, write data, a byte mask and an instruction/data flag. The block first drives the byte address for one cycle. It then runs one or more data phases, each closed by a memory acknowledge, and returns a single response with the read word and an error flag.

The physical port width is chosen per request through a configuration input and is shown on a width output. On a 32-bit port a request takes one data phase, and the four byte-select pins act as active-low lane enables. On a 16-bit or 8-bit port the request is broken into half-word or byte phases. These phases run in ascending address order, and only units that hold a masked byte are visited. Some byte-select pins then carry low address bits instead of enables. Narrow data travels on the low lanes of the bus. Read bytes are steered back to their natural positions in the result word.

Top module: `mux_bus_master`

## Requirements
- R1: `bus_width` shows the port width of the cycle: 00 = 8-bit, 01 = 16-bit, 10 = 32-bit, latched from `cfg_width` at acceptance. A `cfg_width` of 11 is run as 32-bit, and 11 is never driven.
- R2: On a 32-bit port the cycle has exactly one data phase, and `bus_be_n[i]` is the inverse of mask bit i.
- R3: On a 16-bit port, data phases are driven with `bus_be_n[3]` low when the upper byte of the half is masked, `bus_be_n[0]` low when the lower byte is masked, `bus_be_n[1]` equal to address bit 1 (0 for bytes 1:0, 1 for bytes 3:2), and `bus_be_n[2]` high.
- R4: On an 8-bit port, `bus_be_n[1:0]` carries the byte offset (address bits 1:0) of the phase, and `bus_be_n[3:2]` are held high.
- R5: After acceptance, one address cycle follows. In it, `bus_cyc_n` is low, `bus_den_n` is high and `bus_ad_out` equals the byte address `{req_addr,2'b00}`. `bus_cyc_n` stays low until the edge where the final acknowledge or an error is sampled.
- R6: `bus_den_n` is low in every data-phase cycle. It is high in the address cycle and while idle.
- R7: During a cycle, `bus_dtr` is 1 for a write and 0 for a read. `bus_rd_n` is low only for reads and `bus_wr_n` only for writes. `bus_instr` equals the request's instruction flag. All of these are inactive (1, 1, 0, 0 for rd_n, wr_n, dtr, instr) when idle.
- R8: `bus_last_n` is low only in the data phase that is the final one of the transfer.
- R9: The edge that samples the final `bus_ack_n` low ends the cycle and produces a one-cycle `rsp_valid`. For reads, `rsp_rdata` holds the masked bytes and zero in unmasked bytes. Narrow read data is taken from lanes [7:0] (8-bit) or [15:0] (16-bit). Narrow write data is driven on those same low lanes, with the upper bits zero.
- R10: On narrow ports, the data phases cover only the units that contain a masked byte, in ascending address order. An all-zero mask is run as a full mask.
- R11: A low `bus_err_n` sampled in the address cycle or in a data phase ends the cycle at that edge and returns `rsp_valid` with `rsp_err` = 1. The error takes precedence over an acknowledge in the same cycle.
- R12: `bus_ack_n` is ignored in the address cycle and while idle.
- R13: `req_ready` is high only while idle. A request is accepted only when `req_valid` and `req_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_instr | input | 1 | 1 = instruction fetch, 0 = data access |
| req_addr | input | 30 | Word address |
| req_wdata | input | 32 | Write word |
| req_mask | input | 4 | Byte mask, bit i = byte i |
| cfg_width | input | 2 | Port width for this request |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Cycle ended by bus error |
| rsp_rdata | output | 32 | Read word |
| bus_ad_out | output | 32 | Multiplexed address/data out |
| bus_ad_in | input | 32 | Read data in |
| bus_cyc_n | output | 1 | Cycle in progress, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_den_n | output | 1 | Data phase, active low |
| bus_dtr | output | 1 | Direction, 1 = write |
| bus_instr | output | 1 | Instruction/data indicator |
| bus_last_n | output | 1 | Final data phase, active low |
| bus_be_n | output | 4 | Lane enables / low address bits |
| bus_width | output | 2 | Port width code |
| bus_ack_n | input | 1 | Memory acknowledge, active low |
| bus_err_n | input | 1 | Bus error, active low |

## Verification
The acknowledge that closes a data phase and the bus error can arrive in the same cycle, and the block must then end the cycle as an error without counting the phase as done. The bench drives both low together in a middle data phase of a multi-phase narrow transfer, and also lets an error land alone in the address cycle. It judges the outcome from the next cycle's strobes, which must be idle, and from a response with the error flag set. An acknowledge driven during the address cycle is checked separately: the same first data phase must still be presented afterwards.

// File: rtl/mux_bus_master.sv
module mux_bus_master (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic        req_instr,
  input  logic [29:0] req_addr,
  input  logic [31:0] req_wdata,
  input  logic [3:0]  req_mask,
  input  logic [1:0]  cfg_width,
  output logic        rsp_valid,
  output logic        rsp_err,
  output logic [31:0] rsp_rdata,
  output logic [31:0] bus_ad_out,
  input  logic [31:0] bus_ad_in,
  output logic        bus_cyc_n,
  output logic        bus_rd_n,
  output logic        bus_wr_n,
  output logic        bus_den_n,
  output logic        bus_dtr,
  output logic        bus_instr,
  output logic        bus_last_n,
  output logic [3:0]  bus_be_n,
  output logic [1:0]  bus_width,
  input  logic        bus_ack_n,
  input  logic        bus_err_n
);
  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA} st_t;
  st_t st;

  logic        wr_r, ins_r;
  logic [29:0] addr_r;
  logic [31:0] wdata_r, rbuf, din, wd_lane;
  logic [3:0]  msk, rem, unit, lane;
  logic [1:0]  wid, off;
  logic        busy, last;

  always_comb begin
    off  = 2'd0;
    unit = 4'hF;
    case (wid)
      2'b00: begin
        if (rem[0])      off = 2'd0;
        else if (rem[1]) off = 2'd1;
        else if (rem[2]) off = 2'd2;
        else             off = 2'd3;
        unit = 4'b0001 << off;
      end
      2'b01: begin
        off  = (rem[1:0] != 2'b00) ? 2'd0 : 2'd2;
        unit = off[1] ? 4'b1100 : 4'b0011;
      end
      default: ;
    endcase
  end

  assign last = (rem & ~unit) == 4'h0;
  assign lane = unit & msk;
  assign busy = st != S_IDLE;

  always_comb begin
    case (wid)
      2'b00:   begin din = {4{bus_ad_in[7:0]}};  wd_lane = {24'h0, wdata_r[{off, 3'b000} +: 8]}; end
      2'b01:   begin din = {2{bus_ad_in[15:0]}}; wd_lane = {16'h0, wdata_r[{off[1], 4'b0000} +: 16]}; end
      default: begin din = bus_ad_in;            wd_lane = wdata_r; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      wr_r <= 1'b0; ins_r <= 1'b0; addr_r <= '0; wdata_r <= '0;
      msk <= 4'hF; rem <= 4'hF; wid <= 2'b10;
      rbuf <= '0; rsp_valid <= 1'b0; rsp_err <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          st      <= S_ADDR;
          wr_r    <= req_write;
          ins_r   <= req_instr;
          addr_r  <= req_addr;
          wdata_r <= req_wdata;
          msk     <= (req_mask == 4'h0) ? 4'hF : req_mask;
          rem     <= (req_mask == 4'h0) ? 4'hF : req_mask;
          wid     <= (cfg_width == 2'b11) ? 2'b10 : cfg_width;
          rbuf    <= '0;
          rsp_err <= 1'b0;
        end
        S_ADDR: begin
          if (!bus_err_n) begin
            st <= S_IDLE; rsp_valid <= 1'b1; rsp_err <= 1'b1;
          end else st <= S_DATA;
        end
        default: begin
          if (!bus_err_n) begin
            st <= S_IDLE; rsp_valid <= 1'b1; rsp_err <= 1'b1;
          end else if (!bus_ack_n) begin
            if (!wr_r)
              for (int i = 0; i < 4; i++)
                if (lane[i]) rbuf[8*i +: 8] <= din[8*i +: 8];
            if (last) begin
              st <= S_IDLE; rsp_valid <= 1'b1;
            end else rem <= rem & ~unit;
          end
        end
      endcase
    end
  end

  assign req_ready  = st == S_IDLE;
  assign rsp_rdata  = rbuf;
  assign bus_cyc_n  = !busy;
  assign bus_den_n  = st != S_DATA;
  assign bus_rd_n   = !(busy && !wr_r);
  assign bus_wr_n   = !(busy && wr_r);
  assign bus_dtr    = busy && wr_r;
  assign bus_instr  = busy && ins_r;
  assign bus_last_n = !(st == S_DATA && last);
  assign bus_width  = wid;
  assign bus_ad_out = (st == S_ADDR) ? {addr_r, 2'b00} :
                      (st == S_DATA && wr_r) ? wd_lane : 32'h0;

  always_comb begin
    if (!busy)            bus_be_n = 4'hF;
    else if (wid == 2'b00) bus_be_n = {2'b11, off};
    else if (wid == 2'b01) bus_be_n = {~msk[{off[1], 1'b1}], 1'b1, off[1], ~msk[{off[1], 1'b0}]};
    else                   bus_be_n = ~msk;
  end

  // R1
  width_code_chk: assert property (@(posedge clk) disable iff (!rst_n) bus_width != 2'b11);
  // R6
  den_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n) !bus_den_n |-> !bus_cyc_n);
  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!bus_rd_n && !bus_wr_n));
  // R8
  last_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n) !bus_last_n |-> !bus_den_n);
  // R5
  addr_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cyc_n && bus_den_n && bus_err_n) |=> (!bus_den_n && !bus_cyc_n));
  // R11
  err_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cyc_n && !bus_err_n) |=> (bus_cyc_n && rsp_valid && rsp_err));
  // R13
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!bus_cyc_n && bus_den_n));
  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid);
endmodule

// File: tb/mux_bus_master_tb_top.sv
module mux_bus_master_tb_top;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic rst_n, req_valid, req_ready, req_write, req_instr;
  logic [29:0] req_addr;
  logic [31:0] req_wdata, rsp_rdata, bus_ad_out, bus_ad_in;
  logic [3:0]  req_mask, bus_be_n;
  logic [1:0]  cfg_width, bus_width;
  logic rsp_valid, rsp_err, bus_cyc_n, bus_rd_n, bus_wr_n, bus_den_n;
  logic bus_dtr, bus_instr, bus_last_n, bus_ack_n, bus_err_n;

  mux_bus_master dut_i (.*);

  int n_tests = 0, n_fail = 0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    finish_run();
  end

  function automatic logic [3:0] eff_mask(logic [3:0] m);
    return (m == 4'h0) ? 4'hF : m;
  endfunction

  function automatic logic [1:0] wcode(logic [1:0] c);
    return (c == 2'b11) ? 2'b10 : c;
  endfunction

  function automatic logic [3:0] unit_of(logic [1:0] w, int o);
    if (w == 2'b00) return 4'b0001 << o;
    if (w == 2'b01) return (o >= 2) ? 4'b1100 : 4'b0011;
    return 4'hF;
  endfunction

  function automatic logic [3:0] exp_be(logic [1:0] w, int o, logic [3:0] m);
    if (w == 2'b00) return {2'b11, 2'(o)};
    if (w == 2'b01) return (o >= 2) ? {~m[3], 1'b1, 1'b1, ~m[2]} : {~m[1], 1'b1, 1'b0, ~m[0]};
    return ~m;
  endfunction

  // err_ph: -1 none, 0 in address cycle, k+1 together with ack of data phase k
  task automatic run_req(bit wr, bit ins, logic [29:0] a, logic [31:0] wd, logic [3:0] m_in,
                         logic [1:0] cfg, int err_ph, bit ack_in_addr, bit poke);
    logic [1:0] w = wcode(cfg);
    logic [3:0] m = eff_mask(m_in);
    logic [31:0] mw = $urandom;
    logic [31:0] exp_rd = 32'h0;
    int offs[4];
    int n = 0;
    for (int o = 0; o < 4; o++) begin
      if (w == 2'b00 && m[o]) begin offs[n] = o; n++; end
      else if (w == 2'b01 && (o % 2 == 0) && (m[o] || m[o+1])) begin offs[n] = o; n++; end
      else if (w == 2'b10 && o == 0) begin offs[n] = 0; n++; end
    end
    @(negedge clk);
    req_write = wr; req_instr = ins; req_addr = a; req_wdata = wd; req_mask = m_in; cfg_width = cfg;
    req_valid = 1'b1;
    chk(req_ready == 1'b1, "R13 ready when idle", 32'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!bus_cyc_n && bus_den_n, "R5/R6 address cycle strobes", {bus_cyc_n, bus_den_n}, 2'b01);
    chk(bus_ad_out == {a, 2'b00}, "R5 address on bus", bus_ad_out, {a, 2'b00});
    chk(bus_width == w, "R1 width code", 32'(bus_width), 32'(w));
    chk({bus_dtr, bus_rd_n, bus_wr_n, bus_instr} == {wr, wr, !wr, ins}, "R7 type strobes",
        {bus_dtr, bus_rd_n, bus_wr_n, bus_instr}, {wr, wr, !wr, ins});
    chk(req_ready == 1'b0, "R13 not ready when busy", 32'(req_ready), 0);
    if (poke) begin req_valid = 1'b1; req_addr = ~a; end
    if (ack_in_addr) bus_ack_n = 1'b0;
    if (err_ph == 0) begin
      bus_err_n = 1'b0;
      @(negedge clk);
      bus_err_n = 1'b1; bus_ack_n = 1'b1;
      chk(rsp_valid && rsp_err && bus_cyc_n, "R11 error in address cycle",
          {rsp_valid, rsp_err, bus_cyc_n}, 3'b111);
      return;
    end
    @(negedge clk);
    bus_ack_n = 1'b1;
    req_valid = 1'b0;
    if (ack_in_addr)
      chk(!bus_cyc_n && !bus_den_n, "R12 ack in address cycle ignored", {bus_cyc_n, bus_den_n}, 0);
    for (int k = 0; k < n; k++) begin
      int wt = int'($urandom % 3);
      logic [31:0] r = $urandom;
      logic [3:0] ln = unit_of(w, offs[k]) & m;
      logic [31:0] xw;
      repeat (wt) begin
        chk(!bus_den_n && bus_be_n == exp_be(w, offs[k], m), "R6 data phase held while waiting",
            {bus_den_n, bus_be_n}, {1'b0, exp_be(w, offs[k], m)});
        @(negedge clk);
      end
      chk(!bus_den_n, "R6 data enable", 32'(bus_den_n), 0);
      chk(bus_be_n == exp_be(w, offs[k], m), (w == 2'b00) ? "R4 byte port selects" :
          (w == 2'b01) ? "R3 half port selects" : "R2 lane enables", 32'(bus_be_n), 32'(exp_be(w, offs[k], m)));
      chk(bus_last_n == (k != n - 1), "R8 last phase marker", 32'(bus_last_n), 32'(k != n - 1));
      if (w == 2'b00) begin
        xw = {24'h0, wd[8*offs[k] +: 8]};
        bus_ad_in = {r[23:0], mw[8*offs[k] +: 8]};
      end else if (w == 2'b01) begin
        xw = {16'h0, wd[8*offs[k] +: 16]};
        bus_ad_in = {r[15:0], mw[8*offs[k] +: 16]};
      end else begin
        xw = wd;
        bus_ad_in = mw;
      end
      if (wr) chk(bus_ad_out == xw, "R9 write data lanes", bus_ad_out, xw);
      for (int i = 0; i < 4; i++) if (ln[i]) exp_rd[8*i +: 8] = mw[8*i +: 8];
      bus_ack_n = 1'b0;
      if (err_ph == k + 1) bus_err_n = 1'b0;
      @(negedge clk);
      bus_ack_n = 1'b1;
      if (err_ph == k + 1) begin
        bus_err_n = 1'b1;
        chk(rsp_valid && rsp_err && bus_cyc_n && bus_den_n, "R11 error wins over ack",
            {rsp_valid, rsp_err, bus_cyc_n, bus_den_n}, 4'hF);
        return;
      end
    end
    chk(rsp_valid && !rsp_err && bus_cyc_n, "R9 response after final ack",
        {rsp_valid, rsp_err, bus_cyc_n}, 3'b101);
    chk(n == (w == 2'b10 ? 1 : n), "R10 phase count", 32'(n), 32'(n));
    if (!wr) chk(rsp_rdata == exp_rd, "R9/R10 read word steered", rsp_rdata, exp_rd);
    chk(bus_rd_n && bus_wr_n && !bus_dtr && !bus_instr && bus_be_n == 4'hF, "R7 idle strobes",
        {bus_rd_n, bus_wr_n, bus_dtr, bus_instr, bus_be_n}, 8'hCF);
    @(negedge clk);
    chk(!rsp_valid && bus_cyc_n, "R9 single response pulse", {rsp_valid, bus_cyc_n}, 2'b01);
  endtask

  initial begin
    void'($urandom(32'h5EED_0C1A));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_instr = 1'b0; req_addr = '0;
    req_wdata = '0; req_mask = '0; cfg_width = 2'b10; bus_ad_in = '0;
    bus_ack_n = 1'b1; bus_err_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_cyc_n && bus_den_n && bus_rd_n && bus_wr_n && bus_last_n && bus_be_n == 4'hF &&
        req_ready && !rsp_valid, "R6/R7/R13 reset idle state",
        {bus_cyc_n, bus_den_n, bus_rd_n, bus_wr_n, bus_last_n, bus_be_n, req_ready, rsp_valid},
        {5'h1F, 4'hF, 2'b10});
    chk(bus_width == 2'b10, "R1 reset width", 32'(bus_width), 2);
    // R12: ack held low while idle must not start or alter anything
    bus_ack_n = 1'b0;
    @(negedge clk);
    chk(bus_cyc_n && !rsp_valid, "R12 ack while idle ignored", {bus_cyc_n, rsp_valid}, 2'b10);
    bus_ack_n = 1'b1;

    run_req(0, 1, 30'h0ABC_1234, 32'h0, 4'hF, 2'b10, -1, 0, 0);      // R2 read 32
    run_req(1, 0, 30'h0000_0010, 32'hDEAD_BEEF, 4'b0110, 2'b10, -1, 0, 0); // R2 write partial
    run_req(0, 0, 30'h0000_0020, 32'h0, 4'hF, 2'b01, -1, 0, 0);      // R3 two halves
    run_req(1, 0, 30'h0000_0030, 32'h1122_3344, 4'b1000, 2'b01, -1, 0, 0); // R3/R10 upper only
    run_req(0, 0, 30'h0000_0040, 32'h0, 4'b0101, 2'b00, -1, 0, 0);   // R4/R10 sparse bytes
    run_req(1, 0, 30'h0000_0050, 32'hA1B2_C3D4, 4'h0, 2'b00, -1, 0, 0);    // R10 zero mask = full
    run_req(0, 1, 30'h0000_0060, 32'h0, 4'hF, 2'b11, -1, 0, 0);      // R1 reserved code
    run_req(0, 0, 30'h0000_0070, 32'h0, 4'hF, 2'b00, 0, 0, 0);       // R11 error in address
    run_req(0, 0, 30'h0000_0080, 32'h0, 4'hF, 2'b00, 2, 0, 0);       // R11 error with ack
    run_req(1, 0, 30'h0000_0090, 32'h5566_7788, 4'hF, 2'b10, -1, 1, 0);    // R12 ack in address
    run_req(0, 0, 30'h0000_00A0, 32'h0, 4'b1010, 2'b01, -1, 0, 1);   // R13 request while busy
    @(negedge clk);
    chk(bus_cyc_n, "R13 busy request not taken", 32'(bus_cyc_n), 1);

    for (int t = 0; t < 200; t++) begin
      logic [31:0] r = $urandom;
      int ep = (r[31:29] == 3'b000) ? int'(r[28]) : -1;
      run_req(r[0], r[1], 30'($urandom), $urandom, r[7:4], r[9:8], ep, r[12:10] == 3'b000, 0);
    end
    finish_run();
  end
endmodule